// File: doc/BRIEF.md
# Redundant-Thread Branch Outcome Forwarding and Slack-Steered Fetch

This block sits between two copies of one program running as a leading and a trailing thread on shared fetch hardware. When the leading thread commits a branch, it pushes the branch's program counter, its taken flag and its resolved target into a first-in first-out queue. When the trailing thread's fetch reaches a branch, it reads the oldest entry and uses it in place of a predictor. If no fault has occurred, the trailing thread therefore never mispredicts. A trailing branch whose program counter differs from the queued one is reported as a fault.

The same block decides which thread fetches in each cycle. A signed slack counter records how far the leading thread has run ahead, counted in fetched instructions. The leading thread gets fetch priority while the slack is below a target and the queue has room. Otherwise the trailing thread may fetch, but only if any branch it is about to fetch already has its outcome queued. This keeps a roughly constant distance between the threads. The leading thread updates the predictor, and the trailing thread is fed outcomes that have already been resolved.

Top module: `slack_fetch_steer`

## Requirements
- R1: After reset the queue is empty (`trail_outcome_valid` = 0), `outcome_fault` is 0 and the slack is 0. A leading-thread request alone is then granted (`fetch_grant` = 2'b01).
- R2: A push on `lead_commit_br` stores the program counter, taken flag and target. The `trail_outcome_*` outputs present the oldest stored entry, and entries leave in push order.
- R3: `trail_br_fetch` while the queue holds an entry removes the head at the next clock edge. While the queue is empty it changes nothing, and a later push becomes the head.
- R4: A push while the queue holds `DEPTH` entries is dropped. The stored entries and their order are unchanged.
- R5: `fetch_grant` = 2'b01 (leading thread) when `lead_fetch_req` is 1, the slack is below `SLACK_TARGET` and the queue is not full.
- R6: On a cycle with a leading-thread grant, the slack rises by `fetched_count`. On a cycle with a trailing-thread grant, it falls by `fetched_count`, with a floor of -(`SLACK_TARGET`+`FETCH_W`). Once the slack reaches `SLACK_TARGET`, the leading thread is not granted and an eligible trailing request receives 2'b10.
- R7: A trailing request with `trail_needs_outcome` = 1 is granted only when the queue holds an entry. With `trail_needs_outcome` = 0 it needs no entry.
- R8: While the queue is full the leading thread is never granted, and an eligible trailing request receives the grant.
- R9: `trail_br_fetch` with a `trail_br_pc` different from the head's program counter sets `outcome_fault` for exactly the following cycle. A matching program counter leaves it 0, and the head entry is consumed in both cases.
- R10: `fetch_grant` is one-hot or zero. It is zero when neither thread is eligible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lead_commit_br | input | 1 | Leading thread commits a branch this cycle |
| lead_commit_pc | input | PC_W | Committed branch program counter |
| lead_commit_taken | input | 1 | Committed branch was taken |
| lead_commit_target | input | PC_W | Committed branch resolved target |
| trail_br_fetch | input | 1 | Trailing fetch consumes the head outcome this cycle |
| trail_br_pc | input | PC_W | Program counter of the trailing branch being fetched |
| trail_outcome_valid | output | 1 | Head entry available |
| trail_outcome_taken | output | 1 | Head entry taken flag |
| trail_outcome_target | output | PC_W | Head entry target |
| outcome_fault | output | 1 | Program counter mismatch seen in the previous cycle |
| lead_fetch_req | input | 1 | Leading thread wants to fetch |
| trail_fetch_req | input | 1 | Trailing thread wants to fetch |
| trail_needs_outcome | input | 1 | Trailing thread's next fetch block holds a branch |
| fetched_count | input | $clog2(FETCH_W+1) | Instructions fetched this cycle for the granted thread |
| fetch_grant | output | 2 | Bit 0 leading thread, bit 1 trailing thread |

## Verification
The bench builds the block with a four-entry queue, a slack target of eight and a fetch width of four. With these values the queue can be filled in four pushes, so the dropped fifth push and the block on leading fetch while full can be reached quickly. Two four-instruction leading fetches bring the slack to its target, and a single trailing fetch brings it back below. The switch between the threads therefore happens in both directions within a few cycles.

// File: rtl/sfs_pkg.sv
`timescale 1ns/1ps
package sfs_pkg;

    typedef enum logic [1:0] {
        GNT_NONE  = 2'b00,
        GNT_LEAD  = 2'b01,
        GNT_TRAIL = 2'b10
    } grant_e;

    // Next slack value: add leading fetches, remove trailing ones, clamp at a floor.
    function automatic int slack_step(int cur, int up, int down, int floor_v);
        int n;
        n = cur + up - down;
        return (n < floor_v) ? floor_v : n;
    endfunction

endpackage

// File: rtl/outcome_fifo.sv
`timescale 1ns/1ps
module outcome_fifo #(
    parameter int W     = 65,
    parameter int DEPTH = 128
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push_valid,
    input  logic [W-1:0] push_data,
    input  logic         pop_req,
    output logic         head_valid,
    output logic [W-1:0] head_data,
    output logic         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [AW:0]   CAP  = (AW+1)'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rd_ptr, wr_ptr;
    logic [AW:0]   count;
    logic          push_acc, pop_acc;

    assign full       = (count == CAP);
    assign head_valid = (count != '0);
    assign head_data  = mem[rd_ptr];
    assign push_acc   = push_valid && !full;
    assign pop_acc    = pop_req && head_valid;

    always_ff @(posedge clk) begin
        if (push_acc) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_acc) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (pop_acc)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({push_acc, pop_acc})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    AST_FULL_PUSH_DROPPED: assert property (@(posedge clk) disable iff (rst)
        push_valid && full && !pop_req |=> $stable(count) && full); // R4
    AST_POP_ADVANCES: assert property (@(posedge clk) disable iff (rst)
        pop_req && head_valid && !push_valid |=> count == $past(count) - 1'b1); // R3
    AST_EMPTY_POP_NOP: assert property (@(posedge clk) disable iff (rst)
        pop_req && !head_valid && !push_valid |=> !head_valid); // R3

endmodule

// File: rtl/slack_tracker.sv
`timescale 1ns/1ps
module slack_tracker
    import sfs_pkg::*;
#(
    parameter int SLACK_TARGET = 256,
    parameter int FETCH_W      = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  grant_e                       grant,
    input  logic [$clog2(FETCH_W+1)-1:0] fetched_count,
    output logic                         below_target
);
    localparam int SLK_W   = $clog2(SLACK_TARGET + FETCH_W + 1) + 2;
    localparam int SLK_MIN = -(SLACK_TARGET + FETCH_W);

    logic signed [SLK_W-1:0] slack_q;
    int                      up, down;

    always_comb begin
        up   = (grant == GNT_LEAD)  ? int'(fetched_count) : 0;
        down = (grant == GNT_TRAIL) ? int'(fetched_count) : 0;
    end

    assign below_target = (int'(slack_q) < SLACK_TARGET);

    always_ff @(posedge clk) begin
        if (rst) slack_q <= '0;
        else     slack_q <= SLK_W'(slack_step(int'(slack_q), up, down, SLK_MIN));
    end

    AST_SLACK_FLOOR: assert property (@(posedge clk) disable iff (rst)
        int'(slack_q) >= SLK_MIN); // R6
    AST_LEAD_RAISES_SLACK: assert property (@(posedge clk) disable iff (rst)
        grant == GNT_LEAD && fetched_count != '0 |=> slack_q > $past(slack_q)); // R6

endmodule

// File: rtl/fetch_arbiter.sv
`timescale 1ns/1ps
module fetch_arbiter
    import sfs_pkg::*;
(
    input  logic   lead_req,
    input  logic   trail_req,
    input  logic   trail_needs_outcome,
    input  logic   below_target,
    input  logic   q_full,
    input  logic   q_has_entry,
    output grant_e grant
);
    logic lead_ok, trail_ok;

    always_comb begin
        lead_ok  = lead_req && below_target && !q_full;
        trail_ok = trail_req && (!trail_needs_outcome || q_has_entry);
        if (lead_ok)       grant = GNT_LEAD;
        else if (trail_ok) grant = GNT_TRAIL;
        else               grant = GNT_NONE;
    end

endmodule

// File: rtl/slack_fetch_steer.sv
`timescale 1ns/1ps
module slack_fetch_steer
    import sfs_pkg::*;
#(
    parameter int PC_W         = 32,
    parameter int DEPTH        = 128,
    parameter int SLACK_TARGET = 256,
    parameter int FETCH_W      = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         lead_commit_br,
    input  logic [PC_W-1:0]              lead_commit_pc,
    input  logic                         lead_commit_taken,
    input  logic [PC_W-1:0]              lead_commit_target,
    input  logic                         trail_br_fetch,
    input  logic [PC_W-1:0]              trail_br_pc,
    output logic                         trail_outcome_valid,
    output logic                         trail_outcome_taken,
    output logic [PC_W-1:0]              trail_outcome_target,
    output logic                         outcome_fault,
    input  logic                         lead_fetch_req,
    input  logic                         trail_fetch_req,
    input  logic                         trail_needs_outcome,
    input  logic [$clog2(FETCH_W+1)-1:0] fetched_count,
    output logic [1:0]                   fetch_grant
);
    typedef struct packed {
        logic [PC_W-1:0] pc;
        logic            taken;
        logic [PC_W-1:0] target;
    } outcome_t;

    localparam int EW = $bits(outcome_t);

    outcome_t push_ent, head_ent;
    logic     q_full, q_valid, below_target, fault_q;
    grant_e   grant;

    assign push_ent = '{pc: lead_commit_pc, taken: lead_commit_taken, target: lead_commit_target};

    outcome_fifo #(.W(EW), .DEPTH(DEPTH)) u_queue (
        .clk        (clk),
        .rst        (rst),
        .push_valid (lead_commit_br),
        .push_data  (push_ent),
        .pop_req    (trail_br_fetch),
        .head_valid (q_valid),
        .head_data  (head_ent),
        .full       (q_full)
    );

    slack_tracker #(.SLACK_TARGET(SLACK_TARGET), .FETCH_W(FETCH_W)) u_slack (
        .clk           (clk),
        .rst           (rst),
        .grant         (grant),
        .fetched_count (fetched_count),
        .below_target  (below_target)
    );

    fetch_arbiter u_arb (
        .lead_req            (lead_fetch_req),
        .trail_req           (trail_fetch_req),
        .trail_needs_outcome (trail_needs_outcome),
        .below_target        (below_target),
        .q_full              (q_full),
        .q_has_entry         (q_valid),
        .grant               (grant)
    );

    always_ff @(posedge clk) begin
        if (rst) fault_q <= 1'b0;
        else     fault_q <= trail_br_fetch && q_valid && (trail_br_pc != head_ent.pc);
    end

    assign trail_outcome_valid  = q_valid;
    assign trail_outcome_taken  = head_ent.taken;
    assign trail_outcome_target = head_ent.target;
    assign outcome_fault        = fault_q;
    assign fetch_grant          = grant;

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(fetch_grant)); // R10
    AST_TRAIL_HAS_OUTCOME: assert property (@(posedge clk) disable iff (rst)
        fetch_grant[1] && trail_needs_outcome |-> trail_outcome_valid); // R7
    AST_LEAD_NOT_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
        fetch_grant[0] |-> !q_full); // R8
    AST_FAULT_FROM_POP: assert property (@(posedge clk) disable iff (rst)
        outcome_fault |-> $past(trail_br_fetch) && $past(trail_outcome_valid)); // R9
    AST_FAULT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        outcome_fault && !trail_br_fetch |=> !outcome_fault); // R9

endmodule

// File: tb/test_slack_fetch_steer.sv
`timescale 1ns/1ps
module test_slack_fetch_steer;
    localparam int PC_W = 16;
    localparam int DEPTH = 4;
    localparam int TGT = 8;
    localparam int FW = 4;
    localparam int CW = $clog2(FW + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic lead_commit_br = 0, lead_commit_taken = 0;
    logic [PC_W-1:0] lead_commit_pc = '0, lead_commit_target = '0;
    logic trail_br_fetch = 0;
    logic [PC_W-1:0] trail_br_pc = '0;
    logic trail_outcome_valid, trail_outcome_taken, outcome_fault;
    logic [PC_W-1:0] trail_outcome_target;
    logic lead_fetch_req = 0, trail_fetch_req = 0, trail_needs_outcome = 0;
    logic [CW-1:0] fetched_count = '0;
    logic [1:0] fetch_grant;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    slack_fetch_steer #(.PC_W(PC_W), .DEPTH(DEPTH), .SLACK_TARGET(TGT), .FETCH_W(FW)) i_slack_fetch_steer (
        .clk(clk), .rst(rst),
        .lead_commit_br(lead_commit_br), .lead_commit_pc(lead_commit_pc),
        .lead_commit_taken(lead_commit_taken), .lead_commit_target(lead_commit_target),
        .trail_br_fetch(trail_br_fetch), .trail_br_pc(trail_br_pc),
        .trail_outcome_valid(trail_outcome_valid), .trail_outcome_taken(trail_outcome_taken),
        .trail_outcome_target(trail_outcome_target), .outcome_fault(outcome_fault),
        .lead_fetch_req(lead_fetch_req), .trail_fetch_req(trail_fetch_req),
        .trail_needs_outcome(trail_needs_outcome), .fetched_count(fetched_count),
        .fetch_grant(fetch_grant)
    );

    task automatic check(input int act, input int exp, input string req, input string what);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1;
        lead_commit_br = 0; trail_br_fetch = 0;
        lead_fetch_req = 0; trail_fetch_req = 0; trail_needs_outcome = 0;
        fetched_count = '0;
        @(negedge clk);
        @(negedge clk);
        rst = 0;
    endtask

    task automatic push_entry(input logic [PC_W-1:0] pc, input logic tk, input logic [PC_W-1:0] tgt);
        @(negedge clk);
        lead_commit_br = 1; lead_commit_pc = pc; lead_commit_taken = tk; lead_commit_target = tgt;
        @(negedge clk);
        lead_commit_br = 0;
    endtask

    // Check the head, then consume it with the given trailing pc.
    task automatic pop_entry(input logic [PC_W-1:0] pc, input logic tk, input logic [PC_W-1:0] tgt,
                             input string req);
        @(negedge clk);
        #1;
        check(int'(trail_outcome_valid), 1, req, "head valid");
        check(int'(trail_outcome_taken), int'(tk), req, "head taken");
        check(int'(trail_outcome_target), int'(tgt), req, "head target");
        trail_br_fetch = 1; trail_br_pc = pc;
        @(negedge clk);
        trail_br_fetch = 0;
        #1;
        check(int'(outcome_fault), 0, "R9", "no fault on match");
    endtask

    task automatic grant_is(input int exp, input string req, input string what);
        #1;
        check(int'(fetch_grant), exp, req, what);
    endtask

    task automatic t_reset_state();
        do_reset();
        #1;
        check(int'(trail_outcome_valid), 0, "R1", "empty after reset");
        check(int'(outcome_fault), 0, "R1", "fault after reset");
        lead_fetch_req = 1;
        grant_is(1, "R1", "lead granted after reset");
        lead_fetch_req = 0; trail_fetch_req = 1; trail_needs_outcome = 1;
        grant_is(0, "R7", "trail blocked at branch on empty queue");
        trail_needs_outcome = 0;
        grant_is(2, "R7", "trail granted without branch");
        trail_fetch_req = 0;
        grant_is(0, "R10", "no request no grant");
    endtask

    task automatic t_order();
        do_reset();
        for (int i = 0; i < 3; i++)
            push_entry(PC_W'(16'h200 + i), i[0], PC_W'(16'h900 + 3*i));
        @(negedge clk);
        trail_fetch_req = 1; trail_needs_outcome = 1;
        grant_is(2, "R7", "trail granted at branch with entry");
        trail_fetch_req = 0; trail_needs_outcome = 0;
        for (int i = 0; i < 3; i++)
            pop_entry(PC_W'(16'h200 + i), i[0], PC_W'(16'h900 + 3*i), "R2");
        #1;
        check(int'(trail_outcome_valid), 0, "R3", "empty after all pops");
        @(negedge clk);
        trail_br_fetch = 1; trail_br_pc = 16'h0;
        @(negedge clk);
        trail_br_fetch = 0;
        #1;
        check(int'(outcome_fault), 0, "R3", "empty pop raises nothing");
        push_entry(16'h777, 1'b1, 16'h123);
        pop_entry(16'h777, 1'b1, 16'h123, "R3");
    endtask

    task automatic t_full();
        do_reset();
        for (int i = 0; i < DEPTH; i++)
            push_entry(PC_W'(16'h100 + i), ~i[0], PC_W'(16'h500 + i));
        push_entry(16'h1FF, 1'b1, 16'hDEAD);
        @(negedge clk);
        lead_fetch_req = 1; trail_fetch_req = 1;
        grant_is(2, "R8", "full queue steers to trail");
        trail_fetch_req = 0;
        grant_is(0, "R8", "full queue blocks lead");
        lead_fetch_req = 0;
        for (int i = 0; i < DEPTH; i++)
            pop_entry(PC_W'(16'h100 + i), ~i[0], PC_W'(16'h500 + i), "R4");
        #1;
        check(int'(trail_outcome_valid), 0, "R4", "dropped push left no entry");
    endtask

    task automatic t_slack();
        do_reset();
        @(negedge clk);
        lead_fetch_req = 1; trail_fetch_req = 1; fetched_count = CW'(4);
        grant_is(1, "R5", "lead below target");
        @(negedge clk);
        grant_is(1, "R5", "lead at slack 4");
        @(negedge clk);
        fetched_count = CW'(1);
        grant_is(2, "R6", "slack at target steers to trail");
        @(negedge clk);
        grant_is(1, "R6", "trail fetch lowered slack");
        fetched_count = '0;
        lead_fetch_req = 0; trail_fetch_req = 0;
    endtask

    task automatic t_fault();
        do_reset();
        push_entry(16'h300, 1'b0, 16'h340);
        push_entry(16'h310, 1'b1, 16'h380);
        @(negedge clk);
        trail_br_fetch = 1; trail_br_pc = 16'h3AA;
        @(negedge clk);
        trail_br_fetch = 0;
        #1;
        check(int'(outcome_fault), 1, "R9", "mismatch flagged");
        check(int'(trail_outcome_target), 16'h380, "R9", "mismatching entry consumed");
        @(negedge clk);
        #1;
        check(int'(outcome_fault), 0, "R9", "fault lasts one cycle");
        pop_entry(16'h310, 1'b1, 16'h380, "R9");
    endtask

    initial begin
        #(5.0 * 20000);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset_state();
        t_order();
        t_full();
        t_slack();
        t_fault();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule